// File: doc/BRIEF.md
# Framed byte-stream packet transmitter

This block takes 104-bit mesh transactions from a valid/ready source and sends each one as a sequence of bytes on a byte-wide link. A frame strobe is high for as long as a transaction is on the wire. The number of bytes depends on the transaction. A write narrower than 64 bits needs only a header, an address and one data word. Reads and 64-bit writes also carry the source-address word.

The far end has two stall lines, one for reads and one for writes. The block checks them only when it is about to start a packet. A packet that has already begun always runs to its last byte.

A run of 64-bit writes to consecutive doublewords is sent as a burst. Each follow-on write drops its header and address, so only its eight data bytes follow the previous packet with no break in the frame.

Top module: `link_byte_tx`

## Requirements
- R1: After reset, `tx_frame` is low and `tx_byte` is 0.
- R2: The packet input is laid out as {src[31:0] at 103:72, data[31:0] at 71:40, dst[31:0] at 39:8, ctrl[3:0] at 7:4, size[1:0] at 3:2, write at 1, access at 0}. Wire byte 0 is in_pkt[7:0], bytes 1–4 are dst, bytes 5–8 are data and bytes 9–12 are src. Each word is sent most significant byte first.
- R3: A packet accepted while the link is idle appears on the cycle after acceptance, with `tx_frame` high and byte 0 on `tx_byte`.
- R4: A write whose size field is not 3 sends 9 bytes (bytes 0–8). A read, or a write with size 3 (64-bit), sends all 13 bytes.
- R5: While idle, a read (bit 1 = 0) is not accepted and does not start while `rd_wait` is high. `rd_wait` has no effect on writes.
- R6: While idle, a write is not accepted and does not start while `wr_wait` is high. `wr_wait` has no effect on reads. Raising either wait after a packet has started does not cut that packet short.
- R7: Burst continuation happens when all of the following hold on the final byte of a 64-bit write:
  - the next packet is also a 64-bit write;
  - it has the same ctrl field;
  - its dst equals the previous dst + 8;
  - `wr_wait` is low.
  
  The next packet's bytes 5–12 then follow on the next cycle, and the frame stays high.
- R8: Consecutive packets that are not joined as a burst are separated by at least one cycle with `tx_frame` low.
- R9: `in_ready` is high only when the link is idle or on the final byte of the current packet. While idle, it equals the inverse of the wait line for the presented packet's class.
- R10: Whenever `tx_frame` is low, `tx_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet taken on this edge when in_valid is also high |
| in_pkt | input | 104 | Mesh transaction (layout in R2) |
| rd_wait | input | 1 | Far end cannot take new reads |
| wr_wait | input | 1 | Far end cannot take new writes |
| tx_frame | output | 1 | High while a packet or burst is on the link |
| tx_byte | output | 8 | Link byte |

## Verification
Two things can happen in the same cycle: a packet sends its final byte, and the next packet is accepted as a burst continuation. The bench provokes this by holding a chain of doubleword-sequential 64-bit writes valid back to back. It judges the result from the captured stream: the concatenated bytes must match, there must be a single frame rise, and the ready-while-framed count must equal the number of joins.

The same final-byte cycle is also tested against a late-rising `wr_wait`. The started packet must end intact, and the follower must wait, then begin with a fresh header after a gap.

// File: rtl/link_byte_tx.sv
module link_byte_tx (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [103:0] in_pkt,
  input  logic         rd_wait,
  input  logic         wr_wait,
  output logic         tx_frame,
  output logic [7:0]   tx_byte
);
  localparam logic [3:0] LAST_SHORT = 4'd8;
  localparam logic [3:0] LAST_FULL  = 4'd12;
  localparam logic [3:0] BURST_IDX  = 4'd5;

  logic [103:0] cur;
  logic         busy;
  logic [3:0]   idx, last_idx;
  logic [7:0]   sel;

  logic in_wr, in_w64, cur_w64, on_last, seq_next, blocked, take;
  assign in_wr    = in_pkt[1];
  assign in_w64   = in_pkt[1] & (in_pkt[3:2] == 2'b11);
  assign cur_w64  = cur[1] & (cur[3:2] == 2'b11);
  assign on_last  = busy & (idx == last_idx);
  assign seq_next = cur_w64 & in_w64 & (in_pkt[7:4] == cur[7:4])
                  & (in_pkt[39:8] == cur[39:8] + 32'd8) & ~wr_wait;
  assign blocked  = in_wr ? wr_wait : rd_wait;
  assign in_ready = busy ? (on_last & seq_next) : ~blocked;
  assign take     = in_valid & in_ready;

  always_comb begin
    case (idx)
      4'd0:    sel = cur[7:0];
      4'd1:    sel = cur[39:32];
      4'd2:    sel = cur[31:24];
      4'd3:    sel = cur[23:16];
      4'd4:    sel = cur[15:8];
      4'd5:    sel = cur[71:64];
      4'd6:    sel = cur[63:56];
      4'd7:    sel = cur[55:48];
      4'd8:    sel = cur[47:40];
      4'd9:    sel = cur[103:96];
      4'd10:   sel = cur[95:88];
      4'd11:   sel = cur[87:80];
      4'd12:   sel = cur[79:72];
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      busy     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
    end else if (take) begin
      cur      <= in_pkt;
      busy     <= 1'b1;
      idx      <= busy ? BURST_IDX : 4'd0;
      last_idx <= (in_wr && in_pkt[3:2] != 2'b11) ? LAST_SHORT : LAST_FULL;
    end else if (busy) begin
      if (idx == last_idx) busy <= 1'b0;
      else                 idx  <= idx + 4'd1;
    end
  end

  assign tx_frame = busy;
  assign tx_byte  = busy ? sel : 8'h00;
endmodule

// File: rtl/link_byte_tx_chk.sv
module link_byte_tx_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [103:0] in_pkt,
  input logic         rd_wait,
  input logic         wr_wait,
  input logic         tx_frame,
  input logic [7:0]   tx_byte,
  input logic [3:0]   idx,
  input logic [3:0]   last_idx
);
  AST_IDLE_START_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !tx_frame |=> tx_frame && tx_byte == $past(in_pkt[7:0])); // R3
  AST_BURST_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && tx_frame |=> tx_frame && tx_byte == $past(in_pkt[71:64])); // R7
  AST_RD_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_frame && in_valid && !in_pkt[1] && rd_wait |=> !tx_frame); // R5
  AST_WR_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_frame && in_valid && in_pkt[1] && wr_wait |=> !tx_frame); // R6
  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && tx_frame |-> idx == last_idx); // R9
  AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame && idx != last_idx |=> tx_frame); // R6
endmodule

bind link_byte_tx link_byte_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pkt(in_pkt), .rd_wait(rd_wait), .wr_wait(wr_wait),
  .tx_frame(tx_frame), .tx_byte(tx_byte), .idx(idx), .last_idx(last_idx)
);

// File: tb/link_byte_tx_tb.sv
module link_byte_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [103:0] in_pkt = '0;
  logic         rd_wait = 1'b0;
  logic         wr_wait = 1'b0;
  logic         tx_frame;
  logic [7:0]   tx_byte;

  int checks = 0, fails = 0;
  logic [7:0] cap_b [0:255];
  logic [7:0] exp_b [0:255];
  int cap_n, exp_n, rises, exp_r, quiet_bad, rdy_framed;
  logic cap_on = 1'b0, prev_f;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_byte_tx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .rd_wait(rd_wait), .wr_wait(wr_wait),
    .tx_frame(tx_frame), .tx_byte(tx_byte)
  );

  always @(negedge clk) begin
    #2;
    if (cap_on) begin
      if (tx_frame) begin
        cap_b[cap_n] = tx_byte;
        cap_n++;
        if (!prev_f) rises++;
        if (in_ready) rdy_framed++;
      end else if (tx_byte != 8'h00) quiet_bad++;
      prev_f = tx_frame;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [103:0] mk(input bit wr, input logic [1:0] sz, input logic [3:0] ctl,
                                      input logic [31:0] dst, input logic [31:0] dat,
                                      input logic [31:0] src);
    return {src, dat, dst, ctl, sz, wr, 1'b1};
  endfunction

  function automatic logic [7:0] pbyte(input logic [103:0] p, input int k);
    if (k == 0) return p[7:0];
    if (k <= 4) return p[39-8*(k-1) -: 8];
    if (k <= 8) return p[71-8*(k-5) -: 8];
    return p[103-8*(k-9) -: 8];
  endfunction

  task automatic add_exp(input logic [103:0] p, input bit joined);
    int n;
    n = (p[1] && p[3:2] != 2'b11) ? 9 : 13;
    for (int k = (joined ? 5 : 0); k < n; k++) begin
      exp_b[exp_n] = pbyte(p, k);
      exp_n++;
    end
    if (!joined) exp_r++;
  endtask

  task automatic start_cap();
    cap_n = 0; exp_n = 0; rises = 0; exp_r = 0;
    quiet_bad = 0; rdy_framed = 0; prev_f = 1'b0; cap_on = 1'b1;
  endtask

  task automatic end_cap(input string req);
    int bad;
    repeat (20) @(negedge clk);
    #3;
    cap_on = 1'b0;
    bad = 0;
    chk(cap_n == exp_n, {req, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) if (cap_b[i] != exp_b[i]) bad++;
    chk(bad == 0, {req, " byte content mismatches"}, bad, 0);
    chk(rises == exp_r, {req, " frame rises (R8)"}, rises, exp_r);
    chk(quiet_bad == 0, "R10 nonzero byte with frame low", quiet_bad, 0);
  endtask

  task automatic send(input logic [103:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    in_pkt = p;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk(tx_frame == 1'b0, "R1 frame after reset", tx_frame, 0);
    chk(tx_byte == 8'h00, "R1 byte after reset", tx_byte, 0);
    chk(in_ready == 1'b1, "R9 ready when idle", in_ready, 1);
  endtask

  task automatic t_short_write();
    logic [103:0] p = mk(1, 2'b10, 4'h5, 32'h1000_0004, 32'hA1B2_C3D4, 32'hDEAD_BEEF);
    start_cap();
    send(p); drop();
    add_exp(p, 0);
    end_cap("R4 R2 short write");
  endtask

  task automatic t_read();
    logic [103:0] p = mk(0, 2'b10, 4'h3, 32'h8765_4321, 32'h0BAD_F00D, 32'h1357_9BDF);
    start_cap();
    send(p); drop();
    add_exp(p, 0);
    end_cap("R4 R2 read");
  endtask

  task automatic t_burst();
    logic [103:0] p1 = mk(1, 2'b11, 4'h2, 32'h0000_2000, 32'h1111_2222, 32'h3333_4444);
    logic [103:0] p2 = mk(1, 2'b11, 4'h2, 32'h0000_2008, 32'h5555_6666, 32'h7777_8888);
    logic [103:0] p3 = mk(1, 2'b11, 4'h2, 32'h0000_2010, 32'h99AA_BBCC, 32'hDDEE_FF01);
    start_cap();
    send(p1); send(p2); send(p3); drop();
    add_exp(p1, 0); add_exp(p2, 1); add_exp(p3, 1);
    end_cap("R7 burst chain");
    chk(rdy_framed == 2, "R9 ready while framed only at joins", rdy_framed, 2);
  endtask

  task automatic t_nonseq();
    logic [103:0] p1 = mk(1, 2'b11, 4'h2, 32'h0000_3000, 32'h0102_0304, 32'h0506_0708);
    logic [103:0] p2 = mk(1, 2'b11, 4'h2, 32'h0000_3010, 32'h090A_0B0C, 32'h0D0E_0F10);
    start_cap();
    send(p1); send(p2); drop();
    add_exp(p1, 0); add_exp(p2, 0);
    end_cap("R8 R7 non-sequential address");
  endtask

  task automatic t_ctrl_diff();
    logic [103:0] p1 = mk(1, 2'b11, 4'h1, 32'h0000_4000, 32'hAAAA_0001, 32'hBBBB_0001);
    logic [103:0] p2 = mk(1, 2'b11, 4'h9, 32'h0000_4008, 32'hAAAA_0002, 32'hBBBB_0002);
    start_cap();
    send(p1); send(p2); drop();
    add_exp(p1, 0); add_exp(p2, 0);
    end_cap("R7 R8 ctrl mismatch");
  endtask

  task automatic t_short_then_w64();
    logic [103:0] p1 = mk(1, 2'b01, 4'h4, 32'h0000_5000, 32'h0000_ABCD, 32'h0);
    logic [103:0] p2 = mk(1, 2'b11, 4'h4, 32'h0000_5008, 32'hCAFE_0001, 32'hCAFE_0002);
    start_cap();
    send(p1); send(p2); drop();
    add_exp(p1, 0); add_exp(p2, 0);
    end_cap("R7 R4 short write never joins");
  endtask

  task automatic t_rd_wait();
    logic [103:0] w = mk(1, 2'b00, 4'h6, 32'h0000_6000, 32'h0000_0077, 32'h0);
    logic [103:0] r = mk(0, 2'b10, 4'h6, 32'h0000_6100, 32'h0, 32'h0000_6200);
    int seen;
    start_cap();
    rd_wait = 1'b1;
    send(w); drop();
    add_exp(w, 0);
    repeat (12) @(negedge clk);
    in_valid = 1'b1; in_pkt = r;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (in_ready || tx_frame) seen++;
    end
    chk(seen == 0, "R5 read held by rd_wait", seen, 0);
    rd_wait = 1'b0;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    drop();
    add_exp(r, 0);
    end_cap("R5 write passes rd_wait, read after release");
  endtask

  task automatic t_wr_wait();
    logic [103:0] p1 = mk(1, 2'b11, 4'h7, 32'h0000_7000, 32'h1234_5678, 32'h9ABC_DEF0);
    logic [103:0] p2 = mk(1, 2'b11, 4'h7, 32'h0000_7008, 32'h0FED_CBA9, 32'h8765_4321);
    logic [103:0] r  = mk(0, 2'b11, 4'h7, 32'h0000_7100, 32'h0, 32'h0000_7200);
    int seen;
    start_cap();
    send(p1);
    @(negedge clk);
    wr_wait = 1'b1;
    in_pkt = p2;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (in_ready) seen++;
    end
    chk(seen == 0, "R6 R9 write held by wr_wait", seen, 0);
    in_pkt = r;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    in_pkt = p2;
    repeat (16) @(negedge clk);
    wr_wait = 1'b0;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    drop();
    add_exp(p1, 0); add_exp(r, 0); add_exp(p2, 0);
    end_cap("R6 started packet finishes, read passes wr_wait");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short_write();
    t_read();
    t_burst();
    t_nonseq();
    t_ctrl_diff();
    t_short_then_w64();
    t_rd_wait();
    t_wr_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule